// File: doc/BRIEF.md
# Stereo PDM Microphone Capture Interface

This block clocks two pulse-density-modulated microphones that share a single data wire, and splits the interleaved stream into a left bit and a right bit for every microphone clock period. The microphone clock comes from dividing the system clock by 8, 16, 32 or 64. One microphone drives the wire during one half of the clock and its partner drives it during the other half. The block samples the wire at a point chosen within each half and hands the two bits to a downstream decimation filter, each bit with its own one-cycle valid strobe.

An 8-bit control word sets four things: the on/off switch, which of four sampling schemes is used, whether the right output repeats the left microphone, and the divide ratio. When the block is switched off, the microphone clock stays low and nothing is emitted. Changing the switch or the ratio restarts the divider from the start of a fresh period.

Top module: `pdm_mic_capture`

## Requirements
- R1: After reset, with the control word at zero, `pdm_clk_o`, both strobes and both data outputs are 0.
- R2: Control bits 1:0 select the division ratio: 0 gives /8, 1 gives /16, 2 gives /32 and 3 gives /64. For a ratio P the microphone clock is high for system cycles 0..P/2-1 of each period and low for cycles P/2..P-1.
- R3: While control bit 7 (enable) is 0, `pdm_clk_o` is low and no left strobe is issued, starting from the first cycle after the enable is seen low. A right strobe whose left strobe was already issued still completes.
- R4: Each period emits one pair. The left strobe pulses for one cycle together with the rising clock that starts the next period. The right strobe pulses in the cycle after it. Both data outputs are 0 outside their strobes. The data pin passes through two flops, so a bit taken at divider count C is the pin value registered two system edges earlier.
- R5: Control bits 6:5 = 0: the left bit is taken at count 0 (rising edge) and the right bit at count P/2 (falling edge).
- R6: Bits 6:5 = 1: the left bit is taken at count P/4 (middle of the high phase) and the right bit at count 3P/4 (middle of the low phase).
- R7: Bits 6:5 = 2: the left bit is taken at count P/2 and the right bit at count 0.
- R8: Bits 6:5 = 3: the left bit is taken at count 3P/4 and the right bit at count P/4.
- R9: With control bit 3 (mono) at 1 when a pair is emitted, the right output carries the same bit as the left output of that pair.
- R10: A change of enable or ratio holds the clock low for one cycle, then starts a new period at count 0. The first left strobe of the new period appears at the (P+2)th falling system-clock edge after the change, and every left strobe is followed by its right strobe.
- R11: Control bits 4 and 2 have no effect, and changes to them do not restart the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control word: enable, sample scheme, mono, ratio |
| pdm_dat_i | input | 1 | Shared microphone data pin |
| pdm_clk_o | output | 1 | Microphone clock |
| left_o | output | 1 | Left channel bit |
| left_vld_o | output | 1 | Left bit strobe |
| right_o | output | 1 | Right channel bit |
| right_vld_o | output | 1 | Right bit strobe |

## Verification
The assertions assume that the control word is held stable in the system-clock domain. They also assume that the sample scheme and the mono bit may change at any cycle without a restart, so a pair emitted across such a change may mix the old and new settings. The stimulus drives the control word and the data pin only at the falling system-clock edge. It feeds the pin either a pseudo-random bit stream or a delayed copy of the microphone clock, which gives each sampling scheme a known left and right result. Enable and ratio changes are placed at irregular distances, including in the middle of a pair.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
  localparam int unsigned BASE_LOG2   = 3;              // smallest ratio = 2**BASE_LOG2
  localparam int unsigned RATE_W      = 2;
  localparam int unsigned CNT_W       = BASE_LOG2 + (1 << RATE_W) - 1;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PH_RISE_FALL = 2'd0,
    PH_MID_HL    = 2'd1,
    PH_FALL_RISE = 2'd2,
    PH_MID_LH    = 2'd3
  } phase_e;

  typedef struct packed {
    logic              en;
    phase_e            phase;
    logic              rsvd;
    logic              mono;
    logic              spare;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  function automatic logic [CNT_W:0] period_of(input logic [RATE_W-1:0] rate);
    return (CNT_W+1)'(1) << (BASE_LOG2 + 32'(rate));
  endfunction
endpackage

// File: rtl/pdm_sync.sv
module pdm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
  import pdm_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              run_o,
  output logic              go_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pdm_clk_o
);
  logic              en_q, run_q, clk_q, clk_d, restart, go;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W:0]    per_w, half_w, top_w;

  assign per_w  = period_of(rate_i);
  assign half_w = per_w >> 1;
  assign top_w  = per_w - (CNT_W+1)'(1);

  always_comb begin
    restart = (en_i != en_q) || (rate_i != rate_q);
    go      = en_i && !restart;
    cnt_d   = '0;
    if (go && run_q && ({1'b0, cnt_q} != top_w)) cnt_d = cnt_q + CNT_W'(1);
    clk_d   = go && ({1'b0, cnt_d} < half_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      rate_q <= '0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
    end else begin
      en_q   <= en_i;
      rate_q <= rate_i;
      run_q  <= go;
      cnt_q  <= cnt_d;
      clk_q  <= clk_d;
    end
  end

  assign run_o     = run_q;
  assign go_o      = go;
  assign cnt_o     = cnt_q;
  assign pdm_clk_o = clk_q;
  assign last_o    = run_q && go && ({1'b0, cnt_q} == top_w);

  AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == '0) |-> clk_q); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ({1'b0, cnt_q} < period_of(rate_q))); // R2
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_q); // R3
endmodule

// File: rtl/pdm_split.sv
module pdm_split
  import pdm_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              last_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [RATE_W-1:0] rate_i,
  input  phase_e            phase_i,
  input  logic              mono_i,
  input  logic              dat_i,
  output logic              left_o,
  output logic              left_vld_o,
  output logic              right_o,
  output logic              right_vld_o
);
  logic [CNT_W:0] per_w, half_w, qtr_w, cnt_w, l_pt, r_pt;
  logic           l_hold, r_hold, r_pair, r_pend;

  assign per_w  = period_of(rate_i);
  assign half_w = per_w >> 1;
  assign qtr_w  = per_w >> 2;
  assign cnt_w  = {1'b0, cnt_i};

  always_comb begin
    unique case (phase_i)
      PH_RISE_FALL: begin l_pt = '0;              r_pt = half_w;         end
      PH_MID_HL:    begin l_pt = qtr_w;           r_pt = half_w + qtr_w; end
      PH_FALL_RISE: begin l_pt = half_w;          r_pt = '0;             end
      default:      begin l_pt = half_w + qtr_w;  r_pt = qtr_w;          end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_hold      <= 1'b0;
      r_hold      <= 1'b0;
      r_pair      <= 1'b0;
      r_pend      <= 1'b0;
      left_o      <= 1'b0;
      left_vld_o  <= 1'b0;
      right_o     <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      if (run_i && cnt_w == l_pt) l_hold <= dat_i;
      if (run_i && cnt_w == r_pt) r_hold <= dat_i;
      if (last_i) r_pair <= mono_i ? l_hold : r_hold;
      left_vld_o  <= last_i;
      left_o      <= last_i & l_hold;
      r_pend      <= last_i;
      // right half of a pair always completes once its left half is out
      right_vld_o <= r_pend;
      right_o     <= r_pend & r_pair;
    end
  end

  AST_RIGHT_FOLLOWS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |=> right_vld_o); // R4
  AST_RIGHT_NEEDS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_vld_o |-> $past(left_vld_o)); // R10
  AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(left_vld_o && right_vld_o)); // R4
  AST_MONO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (right_vld_o && $past(mono_i, 2)) |-> (right_o == $past(left_o))); // R9
endmodule

// File: rtl/pdm_mic_capture.sv
module pdm_mic_capture
  import pdm_cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ctrl_i,
  input  logic       pdm_dat_i,
  output logic       pdm_clk_o,
  output logic       left_o,
  output logic       left_vld_o,
  output logic       right_o,
  output logic       right_vld_o
);
  ctrl_t            ctrl;
  logic             run, go, last, dat_s;
  logic [CNT_W-1:0] cnt;

  assign ctrl = ctrl_t'(ctrl_i);

  pdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pdm_dat_i),
    .q_o    (dat_s)
  );

  pdm_clk_gen u_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl.en),
    .rate_i    (ctrl.rate),
    .run_o     (run),
    .go_o      (go),
    .last_o    (last),
    .cnt_o     (cnt),
    .pdm_clk_o (pdm_clk_o)
  );

  pdm_split u_split (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .last_i      (last),
    .cnt_i       (cnt),
    .rate_i      (ctrl.rate),
    .phase_i     (ctrl.phase),
    .mono_i      (ctrl.mono),
    .dat_i       (dat_s),
    .left_o      (left_o),
    .left_vld_o  (left_vld_o),
    .right_o     (right_o),
    .right_vld_o (right_vld_o)
  );

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> (!pdm_clk_o && !left_vld_o)); // R3
  AST_LEFT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |-> (pdm_clk_o && !$past(pdm_clk_o))); // R4
  AST_EN_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl.en) |=> !pdm_clk_o); // R10
endmodule

// File: tb/pdm_mic_capture_tb.sv
`timescale 1ns/1ps
module pdm_mic_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       pin = 1'b0;
  logic       pdm_clk_o, left_o, left_vld_o, right_o, right_vld_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0, win = 0, pin_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // expected outputs and model state
  bit  e_clk, e_l, e_lv, e_r, e_rv;
  int  m_cnt;
  bit  m_run, m_en_q, m_lh, m_rh, m_pair, m_pend;
  int  m_rate_q;
  bit  hist[$];

  // window counters
  int  n_rise, n_l, n_r, l_ones, r_ones, orphan;
  bit  prev_clk, prev_lv;

  pdm_mic_capture u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctrl_i      (ctrl),
    .pdm_dat_i   (pin),
    .pdm_clk_o   (pdm_clk_o),
    .left_o      (left_o),
    .left_vld_o  (left_vld_o),
    .right_o     (right_o),
    .right_vld_o (right_vld_o)
  );

  initial forever #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit en, go, s2, last;
    int rate, per, half, qtr, lp, rp, ph;
    en   = ctrl[7];
    rate = int'(ctrl[1:0]);
    ph   = int'(ctrl[6:5]);
    per  = 8 << rate;
    half = per / 2;
    qtr  = per / 4;
    s2   = hist[hist.size()-2];
    hist.push_back(pin);
    void'(hist.pop_front());
    go = en && (en == m_en_q) && (rate == m_rate_q);
    case (ph)
      0: begin lp = 0;          rp = half;   end
      1: begin lp = qtr;        rp = half + qtr; end
      2: begin lp = half;       rp = 0;      end
      default: begin lp = half + qtr; rp = qtr; end
    endcase
    last = m_run && go && (m_cnt == per - 1);
    e_rv = m_pend;
    e_r  = m_pend && m_pair;
    e_lv = last;
    e_l  = last && m_lh;
    if (last) m_pair = ctrl[3] ? m_lh : m_rh;
    m_pend = last;
    if (m_run && m_cnt == lp) m_lh = s2;
    if (m_run && m_cnt == rp) m_rh = s2;
    if (!go)        m_cnt = 0;
    else if (!m_run) m_cnt = 0;
    else            m_cnt = (m_cnt == per - 1) ? 0 : m_cnt + 1;
    m_run    = go;
    e_clk    = go && (m_cnt < half);
    m_en_q   = en;
    m_rate_q = rate;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_en_q = 0; m_rate_q = 0;
      m_lh = 0; m_rh = 0; m_pair = 0; m_pend = 0;
      e_clk = 0; e_l = 0; e_lv = 0; e_r = 0; e_rv = 0;
      hist = {};
      hist.push_back(1'b0);
      hist.push_back(1'b0);
    end else begin
      model_step();
    end
  end

  // compare against model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pdm_clk_o === e_clk, "R2 mic clock", int'(pdm_clk_o), int'(e_clk));
      check({left_vld_o, left_o} === {e_lv, e_l}, "R4 left {vld,bit}",
            int'({left_vld_o, left_o}), int'({e_lv, e_l}));
      check({right_vld_o, right_o} === {e_rv, e_r}, "R4 right {vld,bit}",
            int'({right_vld_o, right_o}), int'({e_rv, e_r}));
      if (win) begin
        if (pdm_clk_o && !prev_clk) n_rise++;
        if (left_vld_o) begin n_l++; l_ones += int'(left_o); end
        if (right_vld_o) begin n_r++; r_ones += int'(right_o); end
        if (right_vld_o && !prev_lv) orphan++;
      end
      prev_clk = pdm_clk_o;
      prev_lv  = left_vld_o;
    end
  end

  // data pin driver
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pin <= pin_mode ? pdm_clk_o : lfsr[0];
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic win_open();
    n_rise = 0; n_l = 0; n_r = 0; l_ones = 0; r_ones = 0; orphan = 0;
    win = 1;
  endtask

  task automatic window(input int n);
    win_open();
    cycles(n);
    win = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    string ptag[4];
    int exp_l[4];
    int exp_r[4];
    ptag = '{"R5", "R6", "R7", "R8"};
    exp_l = '{0, 1, 1, 0};
    exp_r = '{1, 0, 0, 1};

    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check(pdm_clk_o == 0 && left_vld_o == 0 && right_vld_o == 0, "R1 idle strobes/clock",
          int'({pdm_clk_o, left_vld_o, right_vld_o}), 0);
    check(left_o == 0 && right_o == 0, "R1 idle data", int'({left_o, right_o}), 0);

    // R2/R4: each ratio, random data
    for (int r = 0; r < 4; r++) begin
      int p;
      p = 8 << r;
      ctrl = 8'h80 | 8'(r);
      cycles(2 * p + 4);
      window(10 * p);
      check(n_rise == 10, "R2 clock periods in window", n_rise, 10);
      check(n_l == 10, "R4 left strobes per period", n_l, 10);
      check(n_r == 10, "R4 right strobes per period", n_r, 10);
      check(orphan == 0, "R4 right follows left", orphan, 0);
    end

    // R5..R8: pin mirrors the mic clock, ratio /16
    pin_mode = 1;
    for (int ph = 0; ph < 4; ph++) begin
      ctrl = 8'h81 | 8'(ph << 5);
      cycles(3 * 16);
      window(8 * 16);
      check(n_l == 8, {ptag[ph], " pair count"}, n_l, 8);
      check(l_ones == exp_l[ph] * n_l, {ptag[ph], " left bits"}, l_ones, exp_l[ph] * n_l);
      check(r_ones == exp_r[ph] * n_r, {ptag[ph], " right bits"}, r_ones, exp_r[ph] * n_r);
    end

    // R9: mono copies left
    ctrl = 8'hA9;   // enable, scheme 1, mono, /16
    cycles(3 * 16);
    window(8 * 16);
    check(r_ones == n_r && n_r == 8, "R9 mono right equals left=1", r_ones, n_r);
    ctrl = 8'h89;   // enable, scheme 0, mono, /16
    cycles(3 * 16);
    window(8 * 16);
    check(r_ones == 0 && n_r == 8, "R9 mono right equals left=0", r_ones, 0);

    // R3: disabled
    pin_mode = 0;
    ctrl = 8'h09;
    cycles(2);
    window(300);
    check(n_rise == 0, "R3 clock held low", n_rise, 0);
    check(n_l == 0 && n_r == 0, "R3 no strobes", n_l + n_r, 0);

    // R10: start latency from disabled, then ratio change mid-stream
    begin
      int i;
      ctrl = 8'h82;   // /32
      i = 0;
      do begin @(negedge clk); i++; end while (!left_vld_o && i < 200);
      check(i == 34, "R10 first left strobe after enable", i, 34);
      cycles(37);
      ctrl = 8'h80;   // /8
      i = 0;
      do begin @(negedge clk); i++; end while (!left_vld_o && i < 200);
      check(i == 10, "R10 first left strobe after ratio change", i, 10);
      #1;
    end

    // R10: restart stress, enable/ratio changes at irregular points
    ctrl = 8'h00;
    cycles(4);
    win_open();
    for (int k = 0; k < 30; k++) begin
      cycles((k * 7) % 23 + 1);
      ctrl = ((k % 5) == 4) ? 8'h00 : (8'h80 | 8'(k % 4) | 8'((k % 3) << 5));
    end
    ctrl = 8'h00;
    cycles(4);
    win = 0;
    check(orphan == 0, "R10 no orphan right strobe", orphan, 0);
    check(n_l == n_r, "R10 pairs complete", n_r, n_l);

    // R11: bits 4 and 2 ignored, no restart
    ctrl = 8'h81;
    cycles(3 * 16);
    win_open();
    for (int k = 0; k < 64; k++) begin
      cycles(5);
      ctrl = ctrl ^ 8'h14;
    end
    win = 0;
    check(n_rise == 20, "R11 clock unaffected", n_rise, 20);
    check(n_l == 20 && n_r == 20, "R11 pairs unaffected", n_l, 20);

    finish_run();
  end
endmodule